// File: doc/BRIEF.md
# ALU Condition Flag Generator

This block forms the 8-bit result of one ALU or single-bit shift operation. It also produces the five arithmetic status flags that follow from it: half carry (H), negative (N), zero (Z), signed overflow (V) and carry (C). The result path is combinational from the operands. The flags sit in a register that loads on a clock edge only when the update enable is high.

Each operation class updates its own subset of the flags and leaves the others as they were.

- Add and subtract update all five flags.
- Logical operations update N and Z, clear V, and keep H and C.
- Shifts and rotates put the bit pushed out of the operand into C, refresh N and Z, clear V and keep H.

The half carry is kept so that a later decimal-adjust step can correct a packed BCD byte. The carry-in pin feeds add-with-carry, subtract-with-borrow and the rotates through carry.

Top module: `alu_flag_gen`

## Requirements
- R1: Op code 0 (add) gives result = A + B, and op code 1 (add with carry) gives result = A + B + carry_i, both modulo 256. C is 1 exactly when the unsigned sum exceeds 255.
- R2: Op code 2 (subtract) gives result = A - B, and op code 3 (subtract with borrow) gives result = A - B - carry_i, both modulo 256. C is 1 exactly when A is less than B plus the borrow-in.
- R3: H is the carry out of bit 3 for op codes 0 and 1. For op codes 2 and 3 it is the borrow into bit 3, which is set when A[3:0] is less than B[3:0] plus the borrow-in.
- R4: For op codes 0 to 3, V is 1 exactly when the signed two's-complement result lies outside -128..127.
- R5: For every defined op code (0-6, 8-11), N takes result bit 7 and Z is 1 exactly when the result is 0x00.
- R6: Op code 4 gives A AND B, op code 5 gives A OR B and op code 6 gives A XOR B. These clear V and leave H and C unchanged.
- R7: Op code 8 shifts A left with a zero into bit 0 and puts the old bit 7 into C. Op code 9 shifts A right with a zero into bit 7 and puts the old bit 0 into C. Both clear V and keep H.
- R8: Op code 10 rotates A left through carry, with carry_i entering bit 0 and the old bit 7 going to C. Op code 11 rotates A right through carry, with carry_i entering bit 7 and the old bit 0 going to C. Both clear V and keep H.
- R9: With upd_en_i low, all five flags keep their values, while result_o still follows the operands.
- R10: Reset (rst_ni low) clears all five flags. After a clock edge with upd_en_i high, the flags show the new values.
- R11: Undefined op codes (7, 12-15) pass A to result_o and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 8 | Operand A (minuend, and the operand that is shifted) |
| op_b_i | input | 8 | Operand B |
| carry_i | input | 1 | Carry-in, borrow-in or rotate fill bit |
| op_i | input | 4 | Operation code |
| upd_en_i | input | 1 | Flag register load enable |
| result_o | output | 8 | Operation result (combinational) |
| h_o | output | 1 | Half carry or half borrow flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Signed overflow flag |
| c_o | output | 1 | Carry, borrow or shifted-out bit flag |

## Verification
Refreshing some flags while retaining others can happen in the same cycle. A logical or shift operation rewrites N, Z and V, and possibly C, while H and sometimes C must keep what an earlier arithmetic operation left. The bench provokes this by running an add that sets H, C and Z. It then runs an AND, then a shift, on the following cycles. It judges the flag outputs after each edge against a model that holds the retained bits. A long run of random operations, with random enable, mixes held and refreshed flags the same way.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int unsigned OP_W = 4;

  localparam logic [OP_W-1:0] OP_ADD = 4'd0;
  localparam logic [OP_W-1:0] OP_ADC = 4'd1;
  localparam logic [OP_W-1:0] OP_SUB = 4'd2;
  localparam logic [OP_W-1:0] OP_SBC = 4'd3;
  localparam logic [OP_W-1:0] OP_AND = 4'd4;
  localparam logic [OP_W-1:0] OP_OR  = 4'd5;
  localparam logic [OP_W-1:0] OP_XOR = 4'd6;
  localparam logic [OP_W-1:0] OP_SHL = 4'd8;
  localparam logic [OP_W-1:0] OP_SHR = 4'd9;
  localparam logic [OP_W-1:0] OP_ROL = 4'd10;
  localparam logic [OP_W-1:0] OP_ROR = 4'd11;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  localparam int unsigned FLAG_N = $bits(flags_t);

  typedef enum logic [1:0] {
    CLS_ARITH,
    CLS_LOGIC,
    CLS_SHIFT,
    CLS_NONE
  } op_class_e;

  function automatic op_class_e op_class(input logic [OP_W-1:0] op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: op_class = CLS_ARITH;
      OP_AND, OP_OR, OP_XOR:          op_class = CLS_LOGIC;
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: op_class = CLS_SHIFT;
      default:                        op_class = CLS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              use_cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              h_o,
  output logic              v_o,
  output logic              c_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic              ci;
  logic [NIB_W:0]    lo;
  logic [DATA_W:0]   full;

  assign ci = use_cin_i & cin_i;

  // Extra top bit is carry on add, borrow (negative) on subtract
  always_comb begin
    if (sub_i) begin
      lo   = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]} - {{NIB_W{1'b0}}, ci};
      full = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, ci};
    end else begin
      lo   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
      full = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, ci};
    end
  end

  assign res_o = full[DATA_W-1:0];
  assign h_o   = lo[NIB_W];
  assign c_o   = full[DATA_W];
  assign v_o   = sub_i ? ((a_i[MSB] ^ b_i[MSB]) & (res_o[MSB] ^ a_i[MSB]))
                       : (~(a_i[MSB] ^ b_i[MSB]) & (res_o[MSB] ^ a_i[MSB]));
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        sel_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    case (sel_i)
      2'd0:    res_o = a_i & b_i;
      2'd1:    res_o = a_i | b_i;
      2'd2:    res_o = a_i ^ b_i;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              cin_i,
  input  logic              right_i,
  input  logic              rotate_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic fill;
  assign fill = rotate_i & cin_i;

  always_comb begin
    if (right_i) begin
      res_o = {fill, a_i[MSB:1]};
      c_o   = a_i[0];
    end else begin
      res_o = {a_i[MSB-1:0], fill};
      c_o   = a_i[MSB];
    end
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  flags_t mask_i,
  input  flags_t nxt_i,
  output flags_t flags_o
);
  logic [FLAG_N-1:0] q;
  logic [FLAG_N-1:0] mask_v;
  logic [FLAG_N-1:0] nxt_v;

  assign mask_v = mask_i;
  assign nxt_v  = nxt_i;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  q[i] <= 1'b0;
      else if (en_i && mask_v[i])   q[i] <= nxt_v[i];
    end
  end

  assign flags_o = q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q));
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_flag_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              carry_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              upd_en_i,
  output logic [DATA_W-1:0] result_o,
  output logic              h_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o
);
  localparam int unsigned MSB = DATA_W - 1;

  op_class_e         cls;
  logic [DATA_W-1:0] ar_res, lg_res, sh_res;
  logic              ar_h, ar_v, ar_c, sh_c;
  flags_t            nxt, mask, flags_q;

  assign cls = op_class(op_i);

  alu_arith #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_arith (
    .a_i      (op_a_i),
    .b_i      (op_b_i),
    .cin_i    (carry_i),
    .use_cin_i(op_i[0]),
    .sub_i    (op_i[1]),
    .res_o    (ar_res),
    .h_o      (ar_h),
    .v_o      (ar_v),
    .c_o      (ar_c)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i  (op_a_i),
    .b_i  (op_b_i),
    .sel_i(op_i[1:0]),
    .res_o(lg_res)
  );

  alu_shift #(.DATA_W(DATA_W)) u_shift (
    .a_i     (op_a_i),
    .cin_i   (carry_i),
    .right_i (op_i[0]),
    .rotate_i(op_i[1]),
    .res_o   (sh_res),
    .c_o     (sh_c)
  );

  always_comb begin
    nxt  = '0;
    mask = '0;
    case (cls)
      CLS_ARITH: begin
        result_o = ar_res;
        nxt.h = ar_h; nxt.v = ar_v; nxt.c = ar_c;
        mask  = '1;
      end
      CLS_LOGIC: begin
        result_o = lg_res;
        mask.n = 1'b1; mask.z = 1'b1; mask.v = 1'b1;
      end
      CLS_SHIFT: begin
        result_o = sh_res;
        nxt.c  = sh_c;
        mask.n = 1'b1; mask.z = 1'b1; mask.v = 1'b1; mask.c = 1'b1;
      end
      default: result_o = op_a_i;
    endcase
    nxt.n = result_o[MSB];
    nxt.z = (result_o == '0);
  end

  alu_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (upd_en_i),
    .mask_i (mask),
    .nxt_i  (nxt),
    .flags_o(flags_q)
  );

  assign h_o = flags_q.h;
  assign n_o = flags_q.n;
  assign z_o = flags_q.z;
  assign v_o = flags_q.v;
  assign c_o = flags_q.c;

  p_sub_borrow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && op_i == OP_SUB) |=> (c_o == ($past(op_a_i) < $past(op_b_i))));

  p_neg_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && cls != CLS_NONE) |=> (n_o == $past(result_o[MSB])));

  p_logic_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && cls == CLS_LOGIC) |=> ($stable({h_o, c_o}) && !v_o));

  p_shl_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && op_i == OP_SHL) |=> (c_o == $past(op_a_i[MSB])));

  p_undef_keep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls == CLS_NONE) |=> $stable({h_o, n_o, z_o, v_o, c_o}));
endmodule

// File: tb/alu_flag_gen_tb_top.sv
`timescale 1ns/1ps
module alu_flag_gen_tb_top;
  localparam time TCLK = 8ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic       cin = 1'b0;
  logic [3:0] op = '0;
  logic       upd = 1'b0;
  logic [7:0] res;
  logic       h, n, z, v, c;

  int checks = 0;
  int fails  = 0;
  logic [4:0] exp_f = '0;   // {h,n,z,v,c}
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  alu_flag_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(a), .op_b_i(b), .carry_i(cin),
    .op_i(op), .upd_en_i(upd), .result_o(res),
    .h_o(h), .n_o(n), .z_o(z), .v_o(v), .c_o(c)
  );

  function automatic int sx(input logic [7:0] x);
    return x[7] ? int'(x) - 256 : int'(x);
  endfunction

  // Returns {result, h, n, z, v, c}
  function automatic logic [12:0] model(input logic [3:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input logic ci,
                                        input logic [4:0] f);
    logic [7:0] r;
    logic fh, fn, fz, fv, fc;
    int s, k;
    {fh, fn, fz, fv, fc} = f;
    r = x;
    k = (o == 1 || o == 3) ? int'(ci) : 0;
    case (o)
      0, 1: begin
        s = int'(x) + int'(y) + k;
        r = s[7:0]; fc = s > 255;
        fh = (int'(x) % 16 + int'(y) % 16 + k) > 15;
        s = sx(x) + sx(y) + k; fv = s > 127 || s < -128;
      end
      2, 3: begin
        s = int'(x) - int'(y) - k;
        r = s[7:0]; fc = s < 0;
        fh = (int'(x) % 16 - int'(y) % 16 - k) < 0;
        s = sx(x) - sx(y) - k; fv = s > 127 || s < -128;
      end
      4: begin r = x & y; fv = 0; end
      5: begin r = x | y; fv = 0; end
      6: begin r = x ^ y; fv = 0; end
      8: begin r = x << 1; fc = x[7]; fv = 0; end
      9: begin r = x >> 1; fc = x[0]; fv = 0; end
      10: begin r = {x[6:0], ci}; fc = x[7]; fv = 0; end
      11: begin r = {ci, x[7:1]}; fc = x[0]; fv = 0; end
      default: ;
    endcase
    if (o <= 6 || (o >= 8 && o <= 11)) begin
      fn = r[7]; fz = (r == 0);
    end
    return {r, fh, fn, fz, fv, fc};
  endfunction

  task automatic chk_flags(input string tag, input logic [4:0] e);
    checks++;
    if ({h, n, z, v, c} !== e) begin
      fails++;
      $display("FAIL %s: flags hnzvc got %b exp %b", tag, {h, n, z, v, c}, e);
    end
  endtask

  task automatic run_op(input string tag, input logic [3:0] o, input logic [7:0] x,
                        input logic [7:0] y, input logic ci, input logic u);
    logic [12:0] m;
    @(negedge clk);
    op = o; a = x; b = y; cin = ci; upd = u;
    #1;
    m = model(o, x, y, ci, exp_f);
    checks++;
    if (res !== m[12:5]) begin
      fails++;
      $display("FAIL %s: result got %h exp %h", tag, res, m[12:5]);
    end
    @(negedge clk);
    if (u) exp_f = m[4:0];
    chk_flags(tag, exp_f);
    upd = 1'b0;
  endtask

  task automatic t_reset;
    chk_flags("R10 reset", 5'b00000);
    run_op("R10 load", 0, 8'h80, 8'h00, 0, 1);
  endtask

  task automatic t_add;
    run_op("R3 add half", 0, 8'h0F, 8'h01, 0, 1);
    run_op("R1 add wrap", 0, 8'hFF, 8'h01, 0, 1);
    run_op("R4 add ovf", 0, 8'h7F, 8'h01, 0, 1);
    run_op("R1 adc cin", 1, 8'h10, 8'h20, 1, 1);
    run_op("R1 add ignores cin", 0, 8'h10, 8'h20, 1, 1);
    run_op("R4 add neg ovf", 0, 8'h80, 8'hFF, 0, 1);
  endtask

  task automatic t_sub;
    run_op("R3 sub half", 2, 8'h10, 8'h01, 0, 1);
    run_op("R2 sub borrow", 2, 8'h00, 8'h01, 0, 1);
    run_op("R4 sub ovf", 2, 8'h80, 8'h01, 0, 1);
    run_op("R2 sbc zero", 3, 8'h06, 8'h05, 1, 1);
    run_op("R2 sbc borrow edge", 3, 8'h05, 8'h05, 1, 1);
  endtask

  task automatic t_partial;
    run_op("R5 add sets hcz", 0, 8'h0F, 8'hF1, 0, 1);
    run_op("R6 and keeps hc", 4, 8'h80, 8'hFF, 0, 1);
    run_op("R6 or", 5, 8'h00, 8'h00, 0, 1);
    run_op("R6 xor", 6, 8'hA5, 8'h5A, 0, 1);
    run_op("R7 shl keeps h", 8, 8'h81, 8'h00, 0, 1);
  endtask

  task automatic t_shift;
    run_op("R7 shr out", 9, 8'h01, 8'h00, 1, 1);
    run_op("R7 shl no fill", 8, 8'h40, 8'h00, 1, 1);
    run_op("R8 rol", 10, 8'h80, 8'h00, 1, 1);
    run_op("R8 ror", 11, 8'h01, 8'h00, 0, 1);
    run_op("R8 ror fill", 11, 8'h02, 8'h00, 1, 1);
  endtask

  task automatic t_hold;
    run_op("R9 setup", 2, 8'h00, 8'h01, 0, 1);
    run_op("R9 hold", 0, 8'h01, 8'h01, 0, 0);
    run_op("R9 hold logic", 4, 8'h00, 8'h00, 0, 0);
  endtask

  task automatic t_undef;
    run_op("R11 op7", 7, 8'h00, 8'hFF, 1, 1);
    run_op("R11 op12", 12, 8'h80, 8'h01, 0, 1);
    run_op("R11 op15", 15, 8'h3C, 8'h3C, 1, 1);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      run_op("R5 random", 4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
             1'($urandom), 1'($urandom_range(0, 3) != 0));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add();
    t_sub();
    t_partial();
    t_shift();
    t_hold();
    t_undef();
    t_random();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(TCLK * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule